// File: doc/BRIEF.md
# Sleep and Wakeup Sequencer

This block takes a small microcontroller into a low-power sleep state and brings it back out. A firmware write of the sleep bit raises a bus request towards the CPU. The CPU grants it with an acknowledge and stops fetching instructions. On the next falling CPU-clock edge the block raises a chip-wide power-down line, which switches off the fast oscillator, the program memory and the analog references.

While power-down is high the fast CPU clock may be stopped, so wake detection runs entirely from a slow 32 kHz clock. An interrupt wakes the chip when it is pending and its enable bit is set. The CPU's global interrupt enable plays no part. The wakeup steps follow a fixed order of slow-clock edges:
1. A falling-edge synchronizer captures the interrupt.
2. At the next rising edge, power-down is released.
3. At the following rising edge, a one-cycle strobe tells the supply monitors to sample their settled values.
4. At the next falling edge, the bus request is released.

The CPU then drops its acknowledge and resumes. It does not have to service the interrupt.

Top module: `slp_wake_seq`

## Requirements
- R1: When idle and awake, `bus_req` is high right after the first rising `cpu_clk` edge at which `sleep_wr` is sampled high.
- R2: `pwr_down` rises on the first falling `cpu_clk` edge at which `bus_ack` is high. It is never high unless `bus_req` and `bus_ack` are both high.
- R3: An interrupt line wakes the block only when both its bit in `irq_pend` and the same bit in `irq_en` are 1 (1 = enabled). While no such bit exists, `pwr_down` stays high. The block has no global enable input.
- R4: An unmasked interrupt passes two falling `slow_clk` edges of synchronization. `pwr_down` then falls at the first rising `slow_clk` edge after the second of those falling edges.
- R5: Wakeup completes with no `cpu_clk` edges at all while `pwr_down` is high.
- R6: `sample_stb` goes high at the rising `slow_clk` edge after the one that released `pwr_down`. It stays high for exactly one `slow_clk` period.
- R7: `bus_req` falls at the first falling `slow_clk` edge after `sample_stb` rises. While `bus_req` is high, the CPU keeps `bus_ack` high.
- R8: A `sleep_wr` pulse that arrives during a wakeup sequence, before the bus request is released, does not start a new sleep entry.
- R9: While `rst` is high, and after it is released, `pwr_down`, `bus_req` and `sample_stb` are low. This holds even if reset arrives while asleep.
- R10: After a wakeup completes, the block returns to idle and the next sleep write starts a fresh entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Fast CPU clock; may stop while power-down is high |
| slow_clk | input | 1 | Always-running low-frequency clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| sleep_wr | input | 1 | One-cycle strobe: firmware wrote 1 to the sleep bit |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_en | input | IRQ_W | Per-line interrupt enable, 1 = unmasked |
| bus_ack | input | 1 | CPU grant of the bus request; CPU halted while high |
| bus_req | output | 1 | Bus request to the CPU |
| pwr_down | output | 1 | Chip-wide power-down |
| sample_stb | output | 1 | One slow-cycle strobe to sample the supply monitors |

## Verification
The bench stops the modelled CPU clock for as long as power-down is high. A design that waited for a CPU edge to detect the wake would therefore hang there. Each wake is timed edge by edge from the moment the interrupt is raised. A missing synchronizer stage would release power-down one slow edge early, and an extra stage one edge late. A strobe that is too wide, or a release of the bus request on the wrong edge, fails the checks placed between those edges.

Interrupt patterns that are all masked must leave the chip asleep. A sleep write made during the wake sequence must leave the chip awake afterwards, not start a second entry. A reset while asleep must restart the CPU clock and clear every output.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_SLEEP,
    WK_PDOFF,
    WK_SAMPLE,
    WK_RELWAIT
  } wk_state_e;
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/sws_cpu_side.sv
module sws_cpu_side #(
  parameter int SYNC_STAGES = 2
) (
  input  logic cpu_clk,
  input  logic rst,
  input  logic sleep_wr,
  input  logic bus_ack,
  input  logic rel_async,
  output logic req_q,
  output logic pd_q
);
  logic rel_c;

  sws_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rel_sync (
    .clk(cpu_clk), .rst(rst), .d(rel_async), .q(rel_c)
  );

  // Request: set by a sleep write, cleared once the slow side has released it.
  always_ff @(posedge cpu_clk) begin
    if (rst)                  req_q <= 1'b0;
    else if (rel_c)           req_q <= 1'b0;
    else if (sleep_wr)        req_q <= 1'b1;
  end

  // Power-down set half a cycle after the grant is seen.
  always_ff @(negedge cpu_clk) begin
    if (rst)                  pd_q <= 1'b0;
    else if (!req_q)          pd_q <= 1'b0;
    else if (bus_ack)         pd_q <= 1'b1;
  end
endmodule

// File: rtl/sws_slow_side.sv
module sws_slow_side
  import sws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic slow_clk,
  input  logic rst,
  input  logic wake_raw,
  input  logic pd_async,
  input  logic ack_async,
  output logic pd_clr,
  output logic rel,
  output logic sample_stb
);
  wk_state_e st;
  logic      wake_s, pd_s, ack_s;
  logic      slow_clk_n;

  assign slow_clk_n = ~slow_clk;

  // Interrupt captured on falling slow edges.
  sws_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk(slow_clk_n), .rst(rst), .d(wake_raw), .q(wake_s)
  );
  sws_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(slow_clk), .rst(rst), .d(pd_async), .q(pd_s)
  );
  sws_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(slow_clk), .rst(rst), .d(ack_async), .q(ack_s)
  );

  always_ff @(posedge slow_clk) begin
    if (rst) begin
      st         <= WK_IDLE;
      pd_clr     <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      unique case (st)
        WK_IDLE:    if (pd_s) st <= WK_SLEEP;
        WK_SLEEP:   if (wake_s) begin
                      pd_clr <= 1'b1;
                      st     <= WK_PDOFF;
                    end
        WK_PDOFF:   begin
                      sample_stb <= 1'b1;
                      st         <= WK_SAMPLE;
                    end
        WK_SAMPLE:  begin
                      sample_stb <= 1'b0;
                      st         <= WK_RELWAIT;
                    end
        WK_RELWAIT: if (!pd_s && !ack_s) begin
                      pd_clr <= 1'b0;
                      st     <= WK_IDLE;
                    end
        default:    st <= WK_IDLE;
      endcase
    end
  end

  // Release of the bus request on the falling edge inside the strobe cycle.
  always_ff @(negedge slow_clk) begin
    if (rst)                  rel <= 1'b0;
    else if (st == WK_SAMPLE) rel <= 1'b1;
    else if (st == WK_IDLE)   rel <= 1'b0;
  end
endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq #(
  parameter int IRQ_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             cpu_clk,
  input  logic             slow_clk,
  input  logic             rst,
  input  logic             sleep_wr,
  input  logic [IRQ_W-1:0] irq_pend,
  input  logic [IRQ_W-1:0] irq_en,
  input  logic             bus_ack,
  output logic             bus_req,
  output logic             pwr_down,
  output logic             sample_stb
);
  logic req_q, pd_q, pd_clr, rel, wake_raw;

  assign wake_raw = |(irq_pend & irq_en);

  sws_cpu_side #(.SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .cpu_clk(cpu_clk), .rst(rst), .sleep_wr(sleep_wr), .bus_ack(bus_ack),
    .rel_async(rel), .req_q(req_q), .pd_q(pd_q)
  );

  sws_slow_side #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
    .slow_clk(slow_clk), .rst(rst), .wake_raw(wake_raw), .pd_async(pd_q),
    .ack_async(bus_ack), .pd_clr(pd_clr), .rel(rel), .sample_stb(sample_stb)
  );

  // Each output combines a set flop and a clear flop from different domains;
  // the handshake changes only one of the pair at a time, so no glitch.
  assign bus_req  = req_q & ~rel    & ~rst;
  assign pwr_down = pd_q  & ~pd_clr & ~rst;
endmodule

// File: rtl/slp_wake_seq_chk.sv
module slp_wake_seq_chk #(
  parameter int IRQ_W = 8
) (
  input logic             cpu_clk,
  input logic             slow_clk,
  input logic             rst,
  input logic             sleep_wr,
  input logic [IRQ_W-1:0] irq_pend,
  input logic [IRQ_W-1:0] irq_en,
  input logic             bus_ack,
  input logic             bus_req,
  input logic             pwr_down,
  input logic             sample_stb
);
  // R2
  pd_needs_grant_chk: assert property (@(posedge slow_clk) disable iff (rst)
    pwr_down |-> (bus_req && bus_ack));

  // R6
  stb_single_chk: assert property (@(posedge slow_clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R6
  stb_after_pd_off_chk: assert property (@(posedge slow_clk) disable iff (rst)
    $rose(sample_stb) |-> (!pwr_down && !$past(pwr_down)));

  // R7
  req_drop_in_stb_chk: assert property (@(posedge slow_clk) disable iff (rst)
    $fell(bus_req) |-> sample_stb);

  // R7
  ack_drop_after_req_chk: assert property (@(posedge cpu_clk) disable iff (rst)
    $fell(bus_ack) |-> !bus_req);
endmodule

bind slp_wake_seq slp_wake_seq_chk #(.IRQ_W(IRQ_W)) u_chk (
  .cpu_clk(cpu_clk), .slow_clk(slow_clk), .rst(rst), .sleep_wr(sleep_wr),
  .irq_pend(irq_pend), .irq_en(irq_en), .bus_ack(bus_ack), .bus_req(bus_req),
  .pwr_down(pwr_down), .sample_stb(sample_stb)
);

// File: tb/tb_slp_wake_seq.sv
`timescale 1ns/100ps
module tb_slp_wake_seq;
  localparam int IRQ_W = 8;

  logic             ck_free = 1'b0;
  logic             clk_hold = 1'b0;
  logic             slow_clk = 1'b0;
  logic             rst = 1'b1;
  logic             sleep_wr = 1'b0;
  logic             bus_ack = 1'b0;
  logic [IRQ_W-1:0] irq_pend = '0;
  logic [IRQ_W-1:0] irq_en = '0;
  logic             cpu_clk;
  logic             bus_req, pwr_down, sample_stb;
  int               vectors = 0;
  int               miscompares = 0;
  int               cpu_pos_cnt = 0;

  slp_wake_seq #(.IRQ_W(IRQ_W)) dut (
    .cpu_clk(cpu_clk), .slow_clk(slow_clk), .rst(rst), .sleep_wr(sleep_wr),
    .irq_pend(irq_pend), .irq_en(irq_en), .bus_ack(bus_ack),
    .bus_req(bus_req), .pwr_down(pwr_down), .sample_stb(sample_stb)
  );

  // 200 MHz free clock, gated while powered down (held low).
  always #2.5 ck_free = ~ck_free;
  assign cpu_clk = ck_free & ~clk_hold;
  always @(negedge ck_free) begin
    #1;
    clk_hold = pwr_down;
  end

  // Slow clock, 40 fast periods, phase offset from the fast edges.
  initial begin
    #1.3;
    forever #100 slow_clk = ~slow_clk;
  end

  // CPU model: grants the request on the edge after it sees it.
  always @(posedge cpu_clk) begin
    bus_ack     <= rst ? 1'b0 : bus_req;
    cpu_pos_cnt <= cpu_pos_cnt + 1;
  end

  function automatic bit exp_wake(input logic [IRQ_W-1:0] p, input logic [IRQ_W-1:0] e);
    return |(p & e);
  endfunction

  task automatic chk_eq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic do_sleep();
    @(negedge cpu_clk);
    sleep_wr = 1'b1;
    @(posedge cpu_clk);
    #1;
    chk_eq("R1 bus_req after write edge", int'(bus_req), 1);
    chk_eq("R2 no grant yet", int'(bus_ack), 0);
    @(negedge cpu_clk);
    sleep_wr = 1'b0;
    #1;
    chk_eq("R2 pwr_down waits for grant", int'(pwr_down), 0);
    @(posedge cpu_clk);
    #1;
    chk_eq("R2 grant seen", int'(bus_ack), 1);
    chk_eq("R2 pwr_down not before falling edge", int'(pwr_down), 0);
    @(negedge cpu_clk);
    #1;
    chk_eq("R2 pwr_down on falling edge after grant", int'(pwr_down), 1);
    repeat (3) @(posedge slow_clk);
  endtask

  task automatic wake_path(input logic [IRQ_W-1:0] p_in, input logic [IRQ_W-1:0] e_in);
    logic [IRQ_W-1:0] p, e;
    int c0;
    p = p_in;
    e = e_in;
    @(posedge slow_clk);
    #($urandom_range(85, 3));
    irq_pend = p;
    irq_en   = e;
    if (!exp_wake(p, e)) begin
      repeat (4) @(posedge slow_clk);
      #1;
      chk_eq("R3 masked pattern keeps sleep", int'(pwr_down), 1);
      @(posedge slow_clk);
      #($urandom_range(85, 3));
      if (p == '0) p = 1;
      irq_pend = p;
      irq_en   = ~e;
    end
    c0 = cpu_pos_cnt;
    @(negedge slow_clk);
    @(negedge slow_clk);
    #1;
    chk_eq("R4 still asleep before rising edge", int'(pwr_down), 1);
    @(posedge slow_clk);
    #1;
    chk_eq("R4 pwr_down released", int'(pwr_down), 0);
    chk_eq("R5 no cpu edges while asleep", cpu_pos_cnt - c0, 0);
    chk_eq("R6 strobe not yet", int'(sample_stb), 0);
    @(posedge slow_clk);
    #1;
    chk_eq("R6 strobe high", int'(sample_stb), 1);
    chk_eq("R7 request held during strobe", int'(bus_req), 1);
    @(negedge slow_clk);
    #1;
    chk_eq("R7 request released", int'(bus_req), 0);
    chk_eq("R6 strobe still high", int'(sample_stb), 1);
    @(posedge slow_clk);
    #1;
    chk_eq("R6 strobe one cycle", int'(sample_stb), 0);
    irq_pend = '0;
    repeat (5) @(posedge slow_clk);
    #1;
    chk_eq("R10 grant dropped", int'(bus_ack), 0);
    chk_eq("R10 idle no request", int'(bus_req), 0);
    chk_eq("R10 idle awake", int'(pwr_down), 0);
  endtask

  initial begin
    repeat (150000) @(posedge ck_free);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R9 reset state
    repeat (3) @(posedge slow_clk);
    #1;
    chk_eq("R9 reset pwr_down", int'(pwr_down), 0);
    chk_eq("R9 reset bus_req", int'(bus_req), 0);
    chk_eq("R9 reset sample_stb", int'(sample_stb), 0);
    rst = 1'b0;
    repeat (2) @(posedge slow_clk);

    // Directed: single enabled line, then fully masked pattern.
    do_sleep();
    wake_path(8'h01, 8'h01);
    do_sleep();
    wake_path(8'h80, 8'h7f);

    // R8: sleep write during the wake sequence
    do_sleep();
    @(posedge slow_clk);
    #5;
    irq_pend = 8'h04;
    irq_en   = 8'h04;
    @(negedge pwr_down);
    repeat (3) @(negedge cpu_clk);
    sleep_wr = 1'b1;
    @(negedge cpu_clk);
    sleep_wr = 1'b0;
    repeat (8) @(posedge slow_clk);
    #1;
    chk_eq("R8 write ignored, request low", int'(bus_req), 0);
    chk_eq("R8 write ignored, awake", int'(pwr_down), 0);
    irq_pend = '0;
    repeat (2) @(posedge slow_clk);

    // R9: reset while asleep
    do_sleep();
    #1;
    rst = 1'b1;
    repeat (3) @(posedge slow_clk);
    #1;
    chk_eq("R9 reset mid-sleep pwr_down", int'(pwr_down), 0);
    chk_eq("R9 reset mid-sleep bus_req", int'(bus_req), 0);
    chk_eq("R9 reset mid-sleep sample_stb", int'(sample_stb), 0);
    rst = 1'b0;
    repeat (3) @(posedge slow_clk);
    #1;
    chk_eq("R9 after reset awake", int'(pwr_down), 0);
    chk_eq("R9 after reset no grant", int'(bus_ack), 0);

    // R10: recovery and random patterns
    for (int i = 0; i < 12; i++) begin
      do_sleep();
      wake_path(IRQ_W'($urandom), IRQ_W'($urandom));
    end
    finish_run();
  end
endmodule